// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block turns a virtual address into a physical address by fetching one page table entry from memory. Software loads the table's starting address into a base register. Each translation request carries a virtual address and a load/store flag. The walker forms the entry address from the base and the virtual page number, and reads the entry over a valid/ready request port. It then checks the valid bit and the permission bit that applies to the access. The low 12 bits of the address are the offset inside a 4 KiB page and pass through unchanged.

When the access is allowed, the walker may also write the entry back to the same memory location. The write sets the referenced flag on every access, and it sets the dirty flag on a store. The write is skipped when neither flag would change. When a check fails, the walker reports a page fault (entry not valid) or a protection fault (access not permitted) instead of an address. It never writes to memory on a fault.

The walker handles one translation at a time. It shows `busy` from the cycle after it accepts a request until the cycle after its single-cycle completion strobe.

Top module: `ptWalker`

## Requirements
- R1: `reqReady` is high only while no walk is in progress. In the cycle after a request is accepted (`reqValid && reqReady` at a rising edge), `busy` is 1 and `reqReady` is 0.
- R2: A cycle with `baseWrEn` high loads `baseWrData` into the base register. The entry address is base + VPN*4, where VPN = `reqVaddr[31:12]`, and it is fixed when the request is accepted. A base write during a walk does not change the address used by that walk.
- R3: A walk first issues a read (`memReqWrite`=0) at the entry address. `memReqValid`, `memReqAddr` and `memReqWrite` hold steady until `memReqReady` is seen. The read data is taken from the first cycle with `memRspValid` high after the read is accepted.
- R4: The entry is 32 bits wide: bits [31:12] physical page number, bit 4 referenced, bit 3 valid, bit 2 dirty, bit 1 write permission, bit 0 read permission.
- R5: If the valid bit is 0, the walker completes with `donePageFault`=1, `doneProtFault`=0 and `donePaddr`=0, and it issues no memory write.
- R6: If the entry is valid but the needed permission bit is 0 (bit 1 for a store, bit 0 for a load), the walker completes with `doneProtFault`=1, `donePageFault`=0 and `donePaddr`=0, and it issues no memory write.
- R7: On success, `donePaddr` = {entry[31:12], reqVaddr[11:0]} and both fault flags are 0.
- R8: On success, the value written back is the entry read from memory with bit 4 set, and with bit 2 also set for a store. It is written to the same entry address with `memReqWrite`=1.
- R9: The write-back is issued only if that value differs from the entry that was read. A successful access whose flags are already set completes with no memory write.
- R10: `doneValid` is high for exactly one cycle per walk, and `busy` is 0 in the next cycle. The two fault flags are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| baseWrEn | input | 1 | Load the base register |
| baseWrData | input | 32 | New base register value (address of entry 0) |
| reqValid | input | 1 | Translation request present |
| reqReady | output | 1 | Walker can accept a request |
| reqVaddr | input | 32 | Virtual address to translate |
| reqWrite | input | 1 | 1 = store access, 0 = load access |
| busy | output | 1 | A walk is in progress |
| doneValid | output | 1 | One-cycle completion strobe |
| donePaddr | output | 32 | Physical address (0 on a fault) |
| donePageFault | output | 1 | Entry was not valid |
| doneProtFault | output | 1 | Permission denied |
| memReqValid | output | 1 | Memory request present |
| memReqReady | input | 1 | Memory accepts the request |
| memReqWrite | output | 1 | 1 = write-back, 0 = entry read |
| memReqAddr | output | 32 | Entry byte address |
| memReqWdata | output | 32 | Updated entry for the write-back |
| memRspValid | input | 1 | Read data present |
| memRspData | input | 32 | Entry read from memory |

## Verification
The bench goes after these corner cases, each with a checked outcome:
- **Second visit to the same entry.** The referenced flag is already set, so the walk must finish without a write. A design that always writes back would show an extra memory write.
- **Stores to read-only pages, and loads from write-only pages.** A design that checks the wrong permission bit, or ORs the two bits together, would translate an access it should refuse.
- **Invalid entries that have both permission bits set.** These must give a page fault and not a protection fault. A design that orders the checks wrongly would report the wrong fault or return an address.
- **Base register rewritten during a walk.** A design that reads the live base register in place of a latched entry address would fetch the wrong entry and return a mismatched page number.
- **Random traffic with a stalling memory.** Random request-ready stalls and response delays catch designs that drop the request early or sample read data in the wrong cycle.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  // Entry layout: physical page number sits above the page offset bits.
  localparam int unsigned PTE_W     = 32;
  localparam int unsigned BIT_RD    = 0;
  localparam int unsigned BIT_WR    = 1;
  localparam int unsigned BIT_DIRTY = 2;
  localparam int unsigned BIT_VALID = 3;
  localparam int unsigned BIT_REF   = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RDREQ,
    ST_RDWAIT,
    ST_WRREQ,
    ST_DONE
  } walkState_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic latchReq;
    logic latchEntry;
    logic done;
  } ctrlStrobes_t;

  // Verdict on the entry currently on the response bus.
  typedef struct packed {
    logic pageFault;
    logic protFault;
    logic needWb;
  } checkResult_t;
endpackage

// File: rtl/ptwDatapath.sv
module ptwDatapath
  import ptw_pkg::*;
#(
  parameter int unsigned VA_W  = 32,
  parameter int unsigned PA_W  = 32,
  parameter int unsigned OFF_W = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               baseWrEn,
  input  logic [PA_W-1:0]    baseWrData,
  input  logic [VA_W-1:0]    reqVaddr,
  input  logic               reqWrite,
  input  ctrlStrobes_t       strobes,
  input  logic [PTE_W-1:0]   memRspData,
  output checkResult_t       rspCheck,
  output logic [PA_W-1:0]    memReqAddr,
  output logic [PTE_W-1:0]   memReqWdata,
  output logic [PA_W-1:0]    donePaddr,
  output logic               donePageFault,
  output logic               doneProtFault
);
  localparam int unsigned VPN_W = VA_W - OFF_W;
  localparam int unsigned PPN_W = PA_W - OFF_W;

  logic [PA_W-1:0]  baseReg;
  logic [PA_W-1:0]  entryAddrReg;
  logic [OFF_W-1:0] vOffReg;
  logic             isWriteReg;
  logic [PPN_W-1:0] ppnReg;
  logic [PTE_W-1:0] newEntryReg;
  logic             pageFaultReg;
  logic             protFaultReg;

  logic [PA_W-1:0]  entryOffset;
  logic [PTE_W-1:0] updEntry;
  logic             permOk;

  // Entries are 4 bytes, so the index is scaled by 4.
  assign entryOffset = PA_W'({reqVaddr[VA_W-1:OFF_W], 2'b00});

  always_comb begin
    updEntry            = memRspData;
    updEntry[BIT_REF]   = 1'b1;
    if (isWriteReg) updEntry[BIT_DIRTY] = 1'b1;
    permOk              = isWriteReg ? memRspData[BIT_WR] : memRspData[BIT_RD];
    rspCheck.pageFault  = !memRspData[BIT_VALID];
    rspCheck.protFault  = memRspData[BIT_VALID] && !permOk;
    rspCheck.needWb     = memRspData[BIT_VALID] && permOk && (updEntry != memRspData);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseReg <= '0;
    end else if (baseWrEn) begin
      baseReg <= baseWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      entryAddrReg <= '0;
      vOffReg      <= '0;
      isWriteReg   <= 1'b0;
    end else if (strobes.latchReq) begin
      entryAddrReg <= baseReg + entryOffset;
      vOffReg      <= reqVaddr[OFF_W-1:0];
      isWriteReg   <= reqWrite;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ppnReg       <= '0;
      newEntryReg  <= '0;
      pageFaultReg <= 1'b0;
      protFaultReg <= 1'b0;
    end else if (strobes.latchEntry) begin
      ppnReg       <= memRspData[OFF_W +: PPN_W];
      newEntryReg  <= updEntry;
      pageFaultReg <= rspCheck.pageFault;
      protFaultReg <= rspCheck.protFault;
    end
  end

  logic anyFault;
  assign anyFault      = pageFaultReg || protFaultReg;
  assign memReqAddr    = entryAddrReg;
  assign memReqWdata   = newEntryReg;
  assign donePageFault = strobes.done && pageFaultReg;
  assign doneProtFault = strobes.done && protFaultReg;
  assign donePaddr     = (strobes.done && !anyFault) ? {ppnReg, vOffReg} : '0;

  // Number of VPN bits kept for reference by derived widths.
  localparam int unsigned SHIFTED_W = VPN_W + 2;
  if (SHIFTED_W > PA_W) begin : g_trunc_note
    // Upper index bits beyond the physical width wrap; no extra logic.
  end
endmodule

// File: rtl/ptwControl.sv
module ptwControl
  import ptw_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  output logic         reqReady,
  output logic         busy,
  input  logic         memReqReady,
  input  logic         memRspValid,
  input  checkResult_t rspCheck,
  output ctrlStrobes_t strobes,
  output logic         memReqValid,
  output logic         memReqWrite,
  output logic         doneValid
);
  walkState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState   = state;
    strobes     = '0;
    reqReady    = 1'b0;
    memReqValid = 1'b0;
    memReqWrite = 1'b0;
    doneValid   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strobes.latchReq = 1'b1;
          nextState        = ST_RDREQ;
        end
      end
      ST_RDREQ: begin
        memReqValid = 1'b1;
        if (memReqReady) nextState = ST_RDWAIT;
      end
      ST_RDWAIT: begin
        if (memRspValid) begin
          strobes.latchEntry = 1'b1;
          nextState          = rspCheck.needWb ? ST_WRREQ : ST_DONE;
        end
      end
      ST_WRREQ: begin
        memReqValid = 1'b1;
        memReqWrite = 1'b1;
        if (memReqReady) nextState = ST_DONE;
      end
      ST_DONE: begin
        strobes.done = 1'b1;
        doneValid    = 1'b1;
        nextState    = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/ptWalker.sv
module ptWalker
  import ptw_pkg::*;
#(
  parameter int unsigned VA_W  = 32,
  parameter int unsigned PA_W  = 32,
  parameter int unsigned OFF_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baseWrEn,
  input  logic [PA_W-1:0]   baseWrData,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [VA_W-1:0]   reqVaddr,
  input  logic              reqWrite,
  output logic              busy,
  output logic              doneValid,
  output logic [PA_W-1:0]   donePaddr,
  output logic              donePageFault,
  output logic              doneProtFault,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic              memReqWrite,
  output logic [PA_W-1:0]   memReqAddr,
  output logic [PTE_W-1:0]  memReqWdata,
  input  logic              memRspValid,
  input  logic [PTE_W-1:0]  memRspData
);
  ctrlStrobes_t strobes;
  checkResult_t rspCheck;

  ptwControl uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .reqReady    (reqReady),
    .busy        (busy),
    .memReqReady (memReqReady),
    .memRspValid (memRspValid),
    .rspCheck    (rspCheck),
    .strobes     (strobes),
    .memReqValid (memReqValid),
    .memReqWrite (memReqWrite),
    .doneValid   (doneValid)
  );

  ptwDatapath #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W)) uDp (
    .clk           (clk),
    .rstN          (rstN),
    .baseWrEn      (baseWrEn),
    .baseWrData    (baseWrData),
    .reqVaddr      (reqVaddr),
    .reqWrite      (reqWrite),
    .strobes       (strobes),
    .memRspData    (memRspData),
    .rspCheck      (rspCheck),
    .memReqAddr    (memReqAddr),
    .memReqWdata   (memReqWdata),
    .donePaddr     (donePaddr),
    .donePageFault (donePageFault),
    .doneProtFault (doneProtFault)
  );
endmodule

// File: rtl/ptwChecker.sv
module ptwChecker
  import ptw_pkg::*;
#(
  parameter int unsigned VA_W  = 32,
  parameter int unsigned PA_W  = 32,
  parameter int unsigned OFF_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic [VA_W-1:0]   reqVaddr,
  input logic              reqWrite,
  input logic              busy,
  input logic              doneValid,
  input logic [PA_W-1:0]   donePaddr,
  input logic              donePageFault,
  input logic              doneProtFault,
  input logic              memReqValid,
  input logic              memReqReady,
  input logic              memReqWrite,
  input logic [PA_W-1:0]   memReqAddr,
  input logic [PTE_W-1:0]  memReqWdata
);
  logic [OFF_W-1:0] capOff;
  logic             capWrite;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capOff   <= '0;
      capWrite <= 1'b0;
    end else if (reqValid && reqReady) begin
      capOff   <= reqVaddr[OFF_W-1:0];
      capWrite <= reqWrite;
    end
  end

  a_r1_accept_busy: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> (busy && !reqReady));

  a_r3_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=>
      (memReqValid && $stable(memReqAddr) && $stable(memReqWrite)));

  a_r5_fault_paddr_zero: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && (donePageFault || doneProtFault)) |-> (donePaddr == '0));

  a_r7_offset_pass: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && !donePageFault && !doneProtFault) |->
      (donePaddr[OFF_W-1:0] == capOff));

  a_r8_wb_flags: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memReqWrite) |->
      (memReqWdata[BIT_REF] && memReqWdata[BIT_VALID] &&
       (!capWrite || memReqWdata[BIT_DIRTY])));

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> (!doneValid && !busy));

  a_r10_fault_excl: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> !(donePageFault && doneProtFault));
endmodule

bind ptWalker ptwChecker #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W)) uChk (.*);

// File: tb/sim_ptWalker.sv
`timescale 1ns/1ps
module sim_ptWalker;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        baseWrEn = 1'b0;
  logic [31:0] baseWrData = '0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqVaddr = '0;
  logic        reqWrite = 1'b0;
  logic        busy, doneValid, donePageFault, doneProtFault;
  logic [31:0] donePaddr;
  logic        memReqValid, memReqWrite;
  logic        memReqReady = 1'b0;
  logic [31:0] memReqAddr, memReqWdata;
  logic        memRspValid = 1'b0;
  logic [31:0] memRspData = '0;

  always #2.5 clk = ~clk;

  ptWalker u0 (.*);

  logic [31:0] mem [0:255];
  int          wrCount = 0;
  int          pendCnt = 0;
  logic [31:0] pendData = '0;
  int          checks = 0;
  int          fails = 0;

  // Memory model: random accept stalls, 1..3 cycle read latency.
  always @(posedge clk) begin
    if (!rstN) begin
      memReqReady <= 1'b0;
      memRspValid <= 1'b0;
      pendCnt     <= 0;
    end else begin
      memReqReady <= ($urandom % 4) != 0;
      memRspValid <= 1'b0;
      if (pendCnt != 0) begin
        pendCnt <= pendCnt - 1;
        if (pendCnt == 1) begin
          memRspValid <= 1'b1;
          memRspData  <= pendData;
        end
      end
      if (memReqValid && memReqReady) begin
        if (memReqWrite) begin
          mem[memReqAddr[9:2]] <= memReqWdata;
          wrCount <= wrCount + 1;
        end else begin
          pendData <= mem[memReqAddr[9:2]];
          pendCnt  <= 1 + int'($urandom % 3);
        end
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] expEntry(input logic [31:0] e, input bit w);
    return e | 32'h10 | (w ? 32'h4 : 32'h0);
  endfunction
  function automatic bit expPf(input logic [31:0] e);
    return !e[3];
  endfunction
  function automatic bit expProt(input logic [31:0] e, input bit w);
    return e[3] && !(w ? e[1] : e[0]);
  endfunction

  task automatic setBase(input logic [31:0] b);
    @(negedge clk);
    baseWrEn = 1'b1; baseWrData = b;
    @(negedge clk);
    baseWrEn = 1'b0;
  endtask

  task automatic translate(input logic [31:0] base, input logic [31:0] va, input bit w, input bit midBase);
    logic [31:0] addr, old, newE, expPa;
    bit pf, pr, wb;
    int wr0, n;
    addr = base + {va[31:12], 2'b00};
    old  = mem[addr[9:2]];
    pf   = expPf(old);
    pr   = expProt(old, w);
    newE = expEntry(old, w);
    wb   = !pf && !pr && (newE != old);
    expPa = (pf || pr) ? 32'h0 : {old[31:12], va[11:0]};
    wr0  = wrCount;
    @(negedge clk);
    n = 0;
    while (!reqReady && n < 100) begin @(negedge clk); n++; end
    reqValid = 1'b1; reqVaddr = va; reqWrite = w;
    @(negedge clk);
    reqValid = 1'b0;
    chk("R1", "busy after accept", {31'b0, busy}, 32'd1);
    chk("R1", "ready after accept", {31'b0, reqReady}, 32'd0);
    if (midBase) begin
      baseWrEn = 1'b1; baseWrData = base ^ 32'h40;
      @(negedge clk);
      baseWrEn = 1'b0;
    end
    n = 0;
    while (!doneValid && n < 500) begin @(negedge clk); n++; end
    if (!doneValid) begin
      checks++; fails++;
      $display("FAIL R10 walk timeout: actual=%h expected=%h", 32'd0, 32'd1);
    end else begin
      chk(pf ? "R5" : "R5/R6", "page fault flag", {31'b0, donePageFault}, {31'b0, pf});
      chk(pr ? "R6" : "R6/R7", "prot fault flag", {31'b0, doneProtFault}, {31'b0, pr});
      chk(midBase ? "R2" : "R7", "paddr", donePaddr, expPa);
      chk(wb ? "R8" : "R9", "entry in memory", mem[addr[9:2]], wb ? newE : old);
      chk(wb ? "R8" : "R9", "write count", wrCount - wr0, wb ? 32'd1 : 32'd0);
      @(negedge clk);
      chk("R10", "done pulse width", {31'b0, doneValid}, 32'd0);
      chk("R10", "idle after done", {31'b0, busy}, 32'd0);
    end
    if (midBase) setBase(base);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual=%h expected=%h", 32'd0, 32'd1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] b, va;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) mem[i] = $urandom;
    repeat (4) @(negedge clk);
    chk("R1", "reset ready", {31'b0, reqReady}, 32'd1);
    chk("R1", "reset busy", {31'b0, busy}, 32'd0);
    chk("R10", "reset done", {31'b0, doneValid}, 32'd0);
    chk("R3", "reset mem req", {31'b0, memReqValid}, 32'd0);
    rstN = 1'b1;
    setBase(32'h100);
    // Entry fields per R4: [31:12] PPN, 4 ref, 3 valid, 2 dirty, 1 W, 0 R.
    mem[(32'h100 + 3*4) >> 2] = 32'hABCDE_009;      // valid, read only
    translate(32'h100, 32'h0000_3123, 1'b0, 1'b0);   // R8: ref set
    translate(32'h100, 32'h0000_3FFF, 1'b0, 1'b0);   // R9: no write
    translate(32'h100, 32'h0000_3004, 1'b1, 1'b0);   // R6: store to read-only
    mem[(32'h100 + 5*4) >> 2] = 32'h12345_007;      // invalid, all perms
    translate(32'h100, 32'h0000_5010, 1'b0, 1'b0);   // R5
    translate(32'h100, 32'h0000_5010, 1'b1, 1'b0);   // R5
    mem[(32'h100 + 7*4) >> 2] = 32'h55AA5_01A;      // valid, ref, write only
    translate(32'h100, 32'h0000_7ABC, 1'b1, 1'b0);   // R8: dirty set
    translate(32'h100, 32'h0000_7ABC, 1'b1, 1'b0);   // R9: already set
    translate(32'h100, 32'h0000_7000, 1'b0, 1'b0);   // R6: load needs bit 0
    mem[(32'h100 + 9*4) >> 2] = 32'hFEDCB_00B;
    translate(32'h100, 32'h0000_9321, 1'b1, 1'b1);   // R2: base rewritten mid-walk
    for (int k = 0; k < 300; k++) begin
      b  = ($urandom % 9) * 64;
      va = {12'h0, 8'(($urandom % 128)), 12'($urandom)};
      if (k % 20 == 0) setBase(b);
      else b = u0_base_shadow;
      translate(b, va, 1'($urandom), (k % 37) == 5);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  // Bench-side record of the last base value it wrote.
  logic [31:0] u0_base_shadow = '0;
  always @(posedge clk) if (baseWrEn && rstN) u0_base_shadow <= baseWrData;
endmodule